// File: doc/BRIEF.md
# Round-Iterative AES-128 Cipher with ECB and CBC Chaining

This block encrypts or decrypts one 128-bit block at a time under a 128-bit key. It has one round circuit, and that circuit is reused for ten consecutive clock cycles per block. The round circuit serves both directions. A single byte-substitution unit is built around one shared GF(2^8) inverter, and the per-block direction input decides whether it applies the forward table or the inverse table. Decryption runs the inverse rounds directly in inverse-cipher order. The inverse column mix is a small fixed column transform followed by the same forward column-mix network that encryption uses.

A configuration strobe loads a key and an initialisation vector. The block then expands the eleven round keys into a local register file over ten cycles. After that, blocks are presented through a valid/ready handshake. Each block carries its own direction and chaining selection. In ECB the blocks are independent. In CBC a chaining register links successive blocks in the usual way, and that register is reset only by the configuration strobe. Each result appears with a one-cycle done strobe and is held until the next block is accepted.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is held and until a key has been loaded, inReady is 0, outDone is 0 and outBlock is all zeros.
- R2: A cfgLoad pulse accepted at clock edge K keeps inReady low and raises it after edge K+10, when all eleven round keys are available. cfgLoad is only taken while no block is in flight.
- R3: With inDecrypt=0 and inCbc=0, outBlock is the AES-128 encryption of inBlock under cfgKey. Byte 0 of every 128-bit value (key, IV, data) occupies bits 127:120.
- R4: With inDecrypt=1 and inCbc=0, outBlock is the AES-128 decryption of inBlock under cfgKey.
- R5: A block accepted at edge A (inValid and inReady both high) raises outDone for exactly the one cycle after edge A+10. inReady stays low between A and A+10.
- R6: CBC encryption (inDecrypt=0, inCbc=1) encrypts inBlock XOR chain. The resulting ciphertext becomes the new chain value.
- R7: CBC decryption (inDecrypt=1, inCbc=1) outputs the decrypted block XOR chain. The input ciphertext becomes the new chain value.
- R8: ECB blocks neither use nor alter the chain register. A CBC sequence interleaved with ECB blocks gives the same ciphertexts as one without them.
- R9: A new cfgLoad reinitialises the chain register to cfgIv, so a CBC sequence restarts from its first block.
- R10: outBlock stays unchanged from the done cycle until the next block is accepted, regardless of the other inputs.
- R11: For any key, IV and data, ECB decryption inverts ECB encryption. CBC encryption of P under IV equals ECB encryption of P XOR IV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load key and IV, restart key expansion |
| cfgKey | input | 128 | Cipher key |
| cfgIv | input | 128 | Initialisation vector for the chain register |
| inValid | input | 1 | Block offered |
| inReady | output | 1 | Block can be accepted |
| inDecrypt | input | 1 | 1 = decrypt, 0 = encrypt (per block) |
| inCbc | input | 1 | 1 = CBC chaining, 0 = ECB (per block) |
| inBlock | input | 128 | Input data block |
| outDone | output | 1 | One-cycle result strobe |
| outBlock | output | 128 | Result block, held until next acceptance |

## Verification
Published single-block and four-block chained vectors pin the exact byte order, the forward and inverse S-box, the round-key order and both CBC feedback paths. If any one of these is wrong, some vector mismatches. ECB blocks are interleaved into a CBC stream, and the CBC vectors are replayed after a reload, to separate a chain register that ECB corrupts or that a reload fails to reset. Random keys, IVs and data with a fixed seed are checked by round trip and by the identity between CBC and ECB of P XOR IV. These catch errors that still invert themselves or that affect only one direction. The cycle of every done strobe, the ready gap and the hold of the output under changing inputs are observed on each block.

// File: rtl/aes_iter_pkg.sv
`timescale 1ns/1ps
package aes_iter_pkg;

  localparam int BlockW    = 128;
  localparam int NumRounds = 10;
  localparam int NumKeys   = NumRounds + 1;
  localparam int IdxW      = $clog2(NumKeys);

  // Strobes from control to datapath.
  typedef struct packed {
    logic            keyLoad;
    logic            keyStep;
    logic            blkAccept;
    logic            roundStep;
    logic            lastRound;
    logic [IdxW-1:0] idx;
  } ctlStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // Multiplicative inverse as a^254 (zero maps to zero).
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    res  = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gfMul(res, base);
      base = gfMul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [15:0] t;
    t = {b, b} << n;
    return t[15:8];
  endfunction

  // One substitution unit: shared inverter, affine stage chosen by inv.
  function automatic logic [7:0] subByteSel(input logic [7:0] b, input logic inv);
    logic [7:0] pre;
    logic [7:0] y;
    pre = inv ? (rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05) : b;
    y   = gfInv(pre);
    return inv ? y : (y ^ rotl8(y, 1) ^ rotl8(y, 2) ^ rotl8(y, 3) ^ rotl8(y, 4) ^ 8'h63);
  endfunction

  function automatic logic [127:0] subAll(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = subByteSel(s[127-8*i -: 8], inv);
    return o;
  endfunction

  // Byte i = 4*column + row; inv selects the inverse rotation.
  function automatic logic [127:0] shiftRowsSel(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    int src;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        src = inv ? ((c + 4 - r) % 4) : ((c + r) % 4);
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*src+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [127:0] mixCols(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      o[103-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return o;
  endfunction

  // Column times {04}x^2+{05}; followed by mixCols it yields the inverse mix.
  function automatic logic [127:0] preInvMix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] u, v;
    for (int c = 0; c < 4; c++) begin
      u = xtime(xtime(s[127-32*c -: 8] ^ s[111-32*c -: 8]));
      v = xtime(xtime(s[119-32*c -: 8] ^ s[103-32*c -: 8]));
      o[127-32*c -: 8] = s[127-32*c -: 8] ^ u;
      o[119-32*c -: 8] = s[119-32*c -: 8] ^ v;
      o[111-32*c -: 8] = s[111-32*c -: 8] ^ u;
      o[103-32*c -: 8] = s[103-32*c -: 8] ^ v;
    end
    return o;
  endfunction

  function automatic logic [7:0] rconOf(input logic [IdxW-1:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++) if (i < int'(idx)) r = xtime(r);
    return r;
  endfunction

  function automatic logic [127:0] nextRoundKey(input logic [127:0] prev, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t, rot;
    w0  = prev[127:96];
    w1  = prev[95:64];
    w2  = prev[63:32];
    w3  = prev[31:0];
    rot = {w3[23:0], w3[31:24]};
    for (int i = 0; i < 4; i++) t[31-8*i -: 8] = subByteSel(rot[31-8*i -: 8], 1'b0);
    t   = t ^ {rc, 24'h0};
    w0  = w0 ^ t;
    w1  = w1 ^ w0;
    w2  = w2 ^ w1;
    w3  = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_iter_ctrl.sv
`timescale 1ns/1ps
module aes_iter_ctrl
  import aes_iter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgLoad,
  input  logic        inValid,
  output logic        inReady,
  output logic        outDone,
  output ctlStrobes_t ctl
);

  typedef enum logic [1:0] {StIdle, StKeyExp, StRound} ctlState_e;

  localparam logic [IdxW-1:0] LastIdx = IdxW'(NumRounds);

  ctlState_e       st;
  logic [IdxW-1:0] cnt;
  logic            keysValid;
  logic            accept;

  assign inReady = (st == StIdle) && keysValid && !cfgLoad;
  assign accept  = inValid && inReady;

  always_comb begin
    ctl           = '0;
    ctl.keyLoad   = (st == StIdle) && cfgLoad;
    ctl.keyStep   = (st == StKeyExp);
    ctl.blkAccept = accept;
    ctl.roundStep = (st == StRound);
    ctl.lastRound = (st == StRound) && (cnt == LastIdx);
    ctl.idx       = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= StIdle;
      cnt       <= '0;
      keysValid <= 1'b0;
      outDone   <= 1'b0;
    end else begin
      outDone <= 1'b0;
      unique case (st)
        StIdle: begin
          if (cfgLoad) begin
            st        <= StKeyExp;
            cnt       <= IdxW'(1);
            keysValid <= 1'b0;
          end else if (accept) begin
            st  <= StRound;
            cnt <= IdxW'(1);
          end
        end
        StKeyExp: begin
          if (cnt == LastIdx) begin
            st        <= StIdle;
            cnt       <= '0;
            keysValid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        StRound: begin
          if (cnt == LastIdx) begin
            st      <= StIdle;
            cnt     <= '0;
            outDone <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= StIdle;
      endcase
    end
  end

  // R5: the done strobe lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  // R5: final round is followed by the done strobe
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lastRound |=> outDone);

  // R5: no new block while rounds are running
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    ctl.roundStep |-> !inReady);

  // R2: no block while round keys are being built
  a_r2_expand_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    ctl.keyStep |-> !inReady);

endmodule

// File: rtl/aes_iter_dp.sv
`timescale 1ns/1ps
module aes_iter_dp
  import aes_iter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [BlockW-1:0] cfgKey,
  input  logic [BlockW-1:0] cfgIv,
  input  logic              inDecrypt,
  input  logic              inCbc,
  input  logic [BlockW-1:0] inBlock,
  output logic [BlockW-1:0] outBlock
);

  localparam logic [IdxW-1:0] LastIdx = IdxW'(NumRounds);

  logic [BlockW-1:0] rkFile [NumKeys];
  logic [BlockW-1:0] stateReg, chainReg, holdReg, outReg;
  logic              decReg, cbcReg;

  logic [IdxW-1:0]   rkIdx;
  logic [BlockW-1:0] roundKey, whiteIn;
  logic [BlockW-1:0] shifted, subbed, keyed, mixIn, mixed, roundOut, finalOut;

  // Round-key pointer: ascending for encryption, descending for decryption.
  always_comb begin
    if (ctl.blkAccept) rkIdx = inDecrypt ? LastIdx : '0;
    else               rkIdx = decReg ? (LastIdx - ctl.idx) : ctl.idx;
  end

  assign roundKey = (int'(rkIdx) < NumKeys) ? rkFile[rkIdx] : '0;
  assign whiteIn  = (inCbc && !inDecrypt) ? (inBlock ^ chainReg) : inBlock;

  // Shared round: the byte substitution and column mix serve both directions.
  always_comb begin
    shifted  = shiftRowsSel(stateReg, decReg);
    subbed   = subAll(shifted, decReg);
    keyed    = subbed ^ roundKey;
    mixIn    = decReg ? preInvMix(keyed) : subbed;
    mixed    = mixCols(mixIn);
    if (ctl.lastRound) roundOut = keyed;
    else               roundOut = decReg ? mixed : (mixed ^ roundKey);
    finalOut = (decReg && cbcReg) ? (roundOut ^ chainReg) : roundOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NumKeys; k++) rkFile[k] <= '0;
      stateReg <= '0;
      chainReg <= '0;
      holdReg  <= '0;
      outReg   <= '0;
      decReg   <= 1'b0;
      cbcReg   <= 1'b0;
    end else begin
      if (ctl.keyLoad) begin
        rkFile[0] <= cfgKey;
        chainReg  <= cfgIv;
      end
      if (ctl.keyStep) begin
        rkFile[ctl.idx] <= nextRoundKey(rkFile[ctl.idx - 1'b1], rconOf(ctl.idx));
      end
      if (ctl.blkAccept) begin
        stateReg <= whiteIn ^ roundKey;
        holdReg  <= inBlock;
        decReg   <= inDecrypt;
        cbcReg   <= inCbc;
      end
      if (ctl.roundStep) begin
        stateReg <= roundOut;
      end
      if (ctl.lastRound) begin
        outReg <= finalOut;
        if (cbcReg) chainReg <= decReg ? holdReg : roundOut;
      end
    end
  end

  assign outBlock = outReg;

  // R10: result register only moves on a final round
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lastRound |=> $stable(outBlock));

  // R6: after a CBC encryption the chain equals the published ciphertext
  a_r6_chain_is_ct: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lastRound && cbcReg && !decReg) |=> (chainReg == outBlock));

  // R8: ECB blocks leave the chain register alone
  a_r8_ecb_keeps_chain: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lastRound && !cbcReg) |=> $stable(chainReg));

  // R2: key expansion index stays inside the register file
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.keyStep |-> (ctl.idx >= IdxW'(1) && ctl.idx <= LastIdx));

endmodule

// File: rtl/aes_iter_core.sv
`timescale 1ns/1ps
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgLoad,
  input  logic [127:0] cfgKey,
  input  logic [127:0] cfgIv,
  input  logic         inValid,
  output logic         inReady,
  input  logic         inDecrypt,
  input  logic         inCbc,
  input  logic [127:0] inBlock,
  output logic         outDone,
  output logic [127:0] outBlock
);

  ctlStrobes_t ctl;

  aes_iter_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgLoad (cfgLoad),
    .inValid (inValid),
    .inReady (inReady),
    .outDone (outDone),
    .ctl     (ctl)
  );

  aes_iter_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgKey    (cfgKey),
    .cfgIv     (cfgIv),
    .inDecrypt (inDecrypt),
    .inCbc     (inCbc),
    .inBlock   (inBlock),
    .outBlock  (outBlock)
  );

endmodule

// File: tb/aes_iter_core_bench.sv
`timescale 1ns/1ps
module aes_iter_core_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cfgLoad;
  logic [127:0] cfgKey, cfgIv;
  logic         inValid, inReady, inDecrypt, inCbc;
  logic [127:0] inBlock;
  logic         outDone;
  logic [127:0] outBlock;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  aes_iter_core u_aes_iter_core (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .cfgKey    (cfgKey),
    .cfgIv     (cfgIv),
    .inValid   (inValid),
    .inReady   (inReady),
    .inDecrypt (inDecrypt),
    .inCbc     (inCbc),
    .inBlock   (inBlock),
    .outDone   (outDone),
    .outBlock  (outBlock)
  );

  localparam logic [127:0] FipsKey = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FipsPt  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FipsCt  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] SpKey   = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] SpIv    = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] SpEcb1  = 128'h3ad77bb40d7a3660a89ecaf32466ef97;

  logic [127:0] spPt [4];
  logic [127:0] spCt [4];

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // Load key/IV; check the ready gap of the expansion (R2).
  task automatic loadCfg(input logic [127:0] key, input logic [127:0] iv);
    bit ok = 1'b1;
    int firstHigh = -1;
    @(negedge clk);
    cfgLoad = 1'b1; cfgKey = key; cfgIv = iv;
    @(negedge clk);
    cfgLoad = 1'b0; cfgKey = rand128(); cfgIv = rand128();
    for (int j = 0; j <= 10; j++) begin
      if (inReady !== (j == 10)) ok = 1'b0;
      if (inReady === 1'b1 && firstHigh < 0) firstHigh = j;
      if (j < 10) @(negedge clk);
    end
    check(ok, "R2 ready after expansion", 128'(firstHigh), 128'd10);
  endtask

  // One block through the handshake; checks latency (R5) and hold (R10).
  task automatic runBlk(input bit dec, input bit cbc, input logic [127:0] data, output logic [127:0] res);
    bit ok = 1'b1;
    @(negedge clk);
    inValid = 1'b1; inDecrypt = dec; inCbc = cbc; inBlock = data;
    @(negedge clk);
    inValid = 1'b0; inBlock = rand128(); inDecrypt = ~dec; inCbc = ~cbc;
    for (int j = 0; j <= 10; j++) begin
      if (outDone !== (j == 10)) ok = 1'b0;
      if (inReady !== (j == 10)) ok = 1'b0;
      if (j < 10) @(negedge clk);
    end
    check(ok, "R5 done timing and ready gap", {127'd0, outDone}, 128'd1);
    res = outBlock;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      inBlock = rand128(); inDecrypt = $urandom; inCbc = $urandom;
      if (outDone !== 1'b0 || outBlock !== res) ok = 1'b0;
    end
    check(ok, "R10 output held", outBlock, res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] r, r2, k, iv, p;
    void'($urandom(32'h00c0ffee));
    spPt[0] = 128'h6bc1bee22e409f96e93d7e117393172a;
    spPt[1] = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
    spPt[2] = 128'h30c81c46a35ce411e5fbc1191a0a52ef;
    spPt[3] = 128'hf69f2445df4f9b17ad2b417be66c3710;
    spCt[0] = 128'h7649abac8119b246cee98e9b12e9197d;
    spCt[1] = 128'h5086cb9b507219ee95db113a917678b2;
    spCt[2] = 128'h73bed6b8e3c1743b7116e69e22229516;
    spCt[3] = 128'h3ff1caa1681fac09120eca307586e1a7;

    rstN = 1'b0; cfgLoad = 1'b0; cfgKey = '0; cfgIv = '0;
    inValid = 1'b0; inDecrypt = 1'b0; inCbc = 1'b0; inBlock = '0;
    repeat (3) @(negedge clk);
    check(inReady === 1'b0 && outDone === 1'b0 && outBlock === '0, "R1 reset state",
          {126'd0, inReady, outDone} | outBlock, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady === 1'b0 && outDone === 1'b0, "R1 no ready before key", {126'd0, inReady, outDone}, 128'd0);

    // Single-block vectors in both directions
    loadCfg(FipsKey, 128'd0);
    runBlk(1'b0, 1'b0, FipsPt, r);
    check(r === FipsCt, "R3 ECB encrypt vector", r, FipsCt);
    runBlk(1'b1, 1'b0, FipsCt, r);
    check(r === FipsPt, "R4 ECB decrypt vector", r, FipsPt);

    // CBC encryption chain with ECB blocks interleaved
    loadCfg(SpKey, SpIv);
    runBlk(1'b0, 1'b0, spPt[0], r);
    check(r === SpEcb1, "R3 ECB encrypt second key", r, SpEcb1);
    for (int i = 0; i < 4; i++) begin
      runBlk(1'b0, 1'b1, spPt[i], r);
      check(r === spCt[i], "R6 CBC encrypt chain", r, spCt[i]);
      runBlk(1'b0, 1'b0, spPt[0], r);
      check(r === SpEcb1, "R8 ECB unaffected by chain", r, SpEcb1);
    end

    // Reload restarts the chain; CBC decryption chain
    loadCfg(SpKey, SpIv);
    for (int i = 0; i < 4; i++) begin
      runBlk(1'b1, 1'b1, spCt[i], r);
      check(r === spPt[i], "R7 CBC decrypt chain", r, spPt[i]);
      if (i == 1) begin
        runBlk(1'b1, 1'b0, SpEcb1, r2);
        check(r2 === spPt[0], "R8 ECB decrypt leaves chain", r2, spPt[0]);
      end
    end
    loadCfg(SpKey, SpIv);
    runBlk(1'b0, 1'b1, spPt[0], r);
    check(r === spCt[0], "R9 reload resets chain", r, spCt[0]);
    runBlk(1'b0, 1'b1, spPt[1], r);
    check(r === spCt[1], "R9 chain resumes after reload", r, spCt[1]);

    // Random keys, IVs and data
    for (int n = 0; n < 6; n++) begin
      k  = rand128();
      iv = rand128();
      p  = (n == 0) ? 128'd0 : ((n == 1) ? '1 : rand128());
      loadCfg(k, iv);
      runBlk(1'b0, 1'b1, p, r);
      runBlk(1'b0, 1'b0, p ^ iv, r2);
      check(r2 === r, "R11 CBC equals ECB of P xor IV", r2, r);
      runBlk(1'b1, 1'b0, r, r2);
      check(r2 === (p ^ iv), "R11 ECB round trip", r2, p ^ iv);
    end

    summary();
    $finish;
  end

endmodule